// File: doc/BRIEF.md
# Event Frame Builder for a 16-bit Serializer Link

This block packs the data words of one detector event into a fixed frame and drives it, one word per clock, into the 16-bit parallel side of a gigabit serializer. Two control outputs tell the serializer what each cycle is. A cycle can carry a word, it can be an extend cycle, or it can be idle. Every frame has three parts in this order: a status word, then the event's data words, then at least one extend cycle.

A start-of-event strobe opens a frame. The status word is built at that moment from four things: a 4-bit module number, three error flags, the low byte of the beam-clock count, and a sticky flag recording that the previous frame ran short of data. Data words come in on a valid/ready stream. The block accepts exactly the configured number of words, either 8 or 12. The choice depends on how many front-end modules feed the link, and it is fixed for the whole frame when the status word goes out.

A board carries two of these blocks, each with its own stream and its own serializer. The block keeps no state shared between instances.

Top module: `evt_framer`

## Requirements
- R1: While reset is low and on the first cycle after it, `txd` is 0, `tx_en` is 0, `tx_er` is 0 and `din_ready` is 0.
- R2: When `sof` is high at a clock edge with no frame in progress, the next cycle shows the status word with `tx_en`=1 and `tx_er`=0. The status word is {`mod_id`[3:0] in bits 15:12, `err_flags`[2:0] in bits 11:9, the underrun flag in bit 8, `bc_count`[7:0] in bits 7:0}, sampled at that edge.
- R3: `cfg_wide`, sampled at the status-word edge, sets the frame length: 1 gives 12 data words and 0 gives 8. Changing it later has no effect on the current frame. `din_ready` is high only while data words are still owed, and `din_valid` is ignored at all other times.
- R4: A word accepted (`din_valid` and `din_ready` high) at an edge appears on `txd` in the next cycle with `tx_en`=1 and `tx_er`=0.
- R5: The cycle after the last data word is an extend cycle (`tx_en`=0, `tx_er`=1, `txd`=0). With no start pending, the cycle after that is idle (`tx_en`=0, `tx_er`=0).
- R6: `tx_en` and `tx_er` are never high together.
- R7: If `din_valid` is low while `din_ready` is high, the next cycle is an extend cycle and no word is consumed.
- R8: Any underrun during a frame sets bit 8 of the next frame's status word. The flag clears once that status word has been sent.
- R9: A `sof` pulse during a frame is held. The next status word then follows the frame's extend cycle directly, with no idle cycle between. Several pulses within one frame start only one further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | Frame length select: 1 = 12 words, 0 = 8 words |
| mod_id | input | 4 | Module number placed in the status word |
| err_flags | input | 3 | Error flags placed in the status word |
| bc_count | input | 8 | Low byte of the beam-clock counter |
| sof | input | 1 | Start-of-event strobe |
| din | input | 16 | Data word in |
| din_valid | input | 1 | Data word in is valid |
| din_ready | output | 1 | Block accepts a data word this cycle |
| txd | output | 16 | Word to the serializer |
| tx_en | output | 1 | Serializer control: cycle carries a word |
| tx_er | output | 1 | Serializer control: extend cycle when `tx_en` is low |

## Verification
The bench targets six corner cases, each paired with the fault it would expose:

- **Stall just before the last word.** A design that miscounted across a gap would send the extend cycle early or take a thirteenth word.
- **Stall on the very first word.** This catches the same miscounting at the start of a frame.
- **Underrun flag lifetime.** The flag is followed through two status words. A design that never cleared it would mark every later frame, and one that cleared it too early would lose the report.
- **Start strobes during a frame.** Strobes arrive mid-frame, twice within one frame. A design without the pending hold would drop the event, and one that counted pulses would send a spurious extra frame.
- **Length select changed mid-frame.** A design that read the select live would lengthen a narrow frame.
- **Reset mid-frame and valid while idle.** Reset is applied during a frame, and `din_valid` is driven while idle, to show nothing leaks out.

// File: rtl/evt_framer_pkg.sv
package evt_framer_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DATA = 2'd1,
      ST_EXT  = 2'd2
   } fr_state_t;

   typedef enum logic [1:0] {
      OUT_IDLE = 2'd0,
      OUT_HDR  = 2'd1,
      OUT_DATA = 2'd2,
      OUT_EXT  = 2'd3
   } out_sel_t;

endpackage

// File: rtl/evt_framer_hdr.sv
module evt_framer_hdr #(
   parameter int WORD_W = 16,
   parameter int ID_W   = 4,
   parameter int ERR_W  = 3,
   parameter int BC_W   = 8
) (
   input  logic [ID_W-1:0]   mod_id,
   input  logic [ERR_W-1:0]  err_flags,
   input  logic [BC_W-1:0]   bc_count,
   input  logic              underrun,
   output logic [WORD_W-1:0] hdr_word
);
   localparam int UPPER_W = ID_W + ERR_W + 1;

   generate
      if (UPPER_W + BC_W != WORD_W) begin : g_bad_layout
         $error("status word fields do not fill WORD_W");
      end
   endgenerate

   always_comb begin
      hdr_word = {mod_id, err_flags, underrun, bc_count};
   end
endmodule

// File: rtl/evt_framer_seq.sv
module evt_framer_seq
   import evt_framer_pkg::*;
#(
   parameter int N_WIDE   = 12,
   parameter int N_NARROW = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     cfg_wide,
   input  logic     sof,
   input  logic     din_valid,
   output logic     din_ready,
   output out_sel_t sel,
   output logic     underrun,
   output logic     last_beat
);
   localparam int N_MAX = (N_WIDE > N_NARROW) ? N_WIDE : N_NARROW;
   localparam int CNT_W = $clog2(N_MAX + 1);

   fr_state_t        state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] n_last;
   logic             pend;
   logic             start;
   logic             acc;

   always_comb begin
      din_ready = (state == ST_DATA);
      acc       = din_ready && din_valid;
      last_beat = acc && (cnt == n_last);
      start     = (state == ST_IDLE) && (sof || pend);
      unique case (state)
         ST_IDLE: sel = start ? OUT_HDR : OUT_IDLE;
         ST_DATA: sel = acc ? OUT_DATA : OUT_EXT;
         default: sel = OUT_EXT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         n_last   <= '0;
         pend     <= 1'b0;
         underrun <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) state <= ST_DATA;
            ST_DATA: if (last_beat) state <= ST_EXT;
            default: state <= ST_IDLE;
         endcase

         if (start) begin
            cnt    <= '0;
            n_last <= cfg_wide ? CNT_W'(N_WIDE - 1) : CNT_W'(N_NARROW - 1);
         end else if (acc) begin
            cnt <= cnt + 1'b1;
         end

         if (start) pend <= 1'b0;
         else if (sof) pend <= 1'b1;

         if (start) underrun <= 1'b0;
         else if (din_ready && !din_valid) underrun <= 1'b1;
      end
   end

   assert_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      acc |-> (cnt <= n_last));

   assert_pend_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && pend) |=> (state == ST_DATA));
endmodule

// File: rtl/evt_framer_out.sv
module evt_framer_out
   import evt_framer_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  out_sel_t          sel,
   input  logic [WORD_W-1:0] hdr_word,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] txd,
   output logic              tx_en,
   output logic              tx_er
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         txd   <= '0;
         tx_en <= 1'b0;
         tx_er <= 1'b0;
      end else begin
         unique case (sel)
            OUT_HDR:  begin txd <= hdr_word; tx_en <= 1'b1; tx_er <= 1'b0; end
            OUT_DATA: begin txd <= din;      tx_en <= 1'b1; tx_er <= 1'b0; end
            OUT_EXT:  begin txd <= '0;       tx_en <= 1'b0; tx_er <= 1'b1; end
            default:  begin txd <= '0;       tx_en <= 1'b0; tx_er <= 1'b0; end
         endcase
      end
   end

   assert_no_en_er_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_en && tx_er));
endmodule

// File: rtl/evt_framer.sv
module evt_framer
   import evt_framer_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int ID_W     = 4,
   parameter int ERR_W    = 3,
   parameter int BC_W     = 8,
   parameter int N_WIDE   = 12,
   parameter int N_NARROW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wide,
   input  logic [ID_W-1:0]   mod_id,
   input  logic [ERR_W-1:0]  err_flags,
   input  logic [BC_W-1:0]   bc_count,
   input  logic              sof,
   input  logic [WORD_W-1:0] din,
   input  logic              din_valid,
   output logic              din_ready,
   output logic [WORD_W-1:0] txd,
   output logic              tx_en,
   output logic              tx_er
);
   generate
      if (N_NARROW < 1 || N_WIDE < 1) begin : g_bad_len
         $error("frame lengths must be at least one word");
      end
   endgenerate

   out_sel_t          sel;
   logic              underrun;
   logic              last_beat;
   logic [WORD_W-1:0] hdr_word;

   evt_framer_hdr #(
      .WORD_W(WORD_W), .ID_W(ID_W), .ERR_W(ERR_W), .BC_W(BC_W)
   ) u_hdr (
      .mod_id(mod_id), .err_flags(err_flags), .bc_count(bc_count),
      .underrun(underrun), .hdr_word(hdr_word)
   );

   evt_framer_seq #(
      .N_WIDE(N_WIDE), .N_NARROW(N_NARROW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .sof(sof),
      .din_valid(din_valid), .din_ready(din_ready), .sel(sel),
      .underrun(underrun), .last_beat(last_beat)
   );

   evt_framer_out #(
      .WORD_W(WORD_W)
   ) u_out (
      .clk(clk), .rst_n(rst_n), .sel(sel), .hdr_word(hdr_word), .din(din),
      .txd(txd), .tx_en(tx_en), .tx_er(tx_er)
   );

   assert_ext_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      last_beat |=> ##1 (tx_er && !tx_en));

   assert_underrun_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (din_ready && !din_valid) |=> (tx_er && !tx_en));

   assert_hdr_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == OUT_HDR) |-> !tx_en);

   assert_hdr_ctl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == OUT_HDR) |=> (tx_en && !tx_er));
endmodule

// File: tb/sim_evt_framer.sv
`timescale 1ns/1ps
module sim_evt_framer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wide = 1'b0;
   logic [3:0]  mod_id = '0;
   logic [2:0]  err_flags = '0;
   logic [7:0]  bc_count = '0;
   logic        sof = 1'b0;
   logic [15:0] din = '0;
   logic        din_valid = 1'b0;
   logic        din_ready;
   logic [15:0] txd;
   logic        tx_en;
   logic        tx_er;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   evt_framer u0 (
      .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .mod_id(mod_id),
      .err_flags(err_flags), .bc_count(bc_count), .sof(sof), .din(din),
      .din_valid(din_valid), .din_ready(din_ready), .txd(txd),
      .tx_en(tx_en), .tx_er(tx_er)
   );

   // fields: wide[23] id[22:19] err[18:16] bc[15:8] unused[7:4] stall[3:0] (15 = none)
   localparam logic [23:0] VEC [5] = '{
      {1'b1, 4'h3, 3'b000, 8'hA5, 4'h0, 4'hF},
      {1'b0, 4'hC, 3'b101, 8'h7E, 4'h0, 4'd2},
      {1'b1, 4'h7, 3'b010, 8'hFF, 4'h0, 4'd11},
      {1'b0, 4'hF, 3'b111, 8'h00, 4'h0, 4'd0},
      {1'b1, 4'h0, 3'b001, 8'hC3, 4'h0, 4'hF}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_ctl(input string req, input logic [15:0] d, input logic en, input logic er);
      check(req, {14'd0, tx_en, tx_er, txd}, {14'd0, en, er, d});
   endtask

   task automatic set_cfg(input logic w, input logic [3:0] id, input logic [2:0] e, input logic [7:0] bc);
      cfg_wide = w; mod_id = id; err_flags = e; bc_count = bc;
   endtask

   task automatic pulse_sof();
      @(negedge clk); sof = 1'b1;
      @(negedge clk); sof = 1'b0;
   endtask

   task automatic expect_hdr(input string req, input logic urun);
      check_ctl(req, {mod_id, err_flags, urun, bc_count}, 1'b1, 1'b0);
      check({req, " ready"}, {31'd0, din_ready}, 32'd1);
   endtask

   // sof_mask bit i: raise sof together with word i
   task automatic send_words(input int n, input logic [15:0] base, input int stall, input int sof_mask);
      for (int i = 0; i < n; i++) begin
         if (i == stall) begin
            din_valid = 1'b0;
            @(negedge clk);
            check_ctl("R7 underrun extend", 16'h0, 1'b0, 1'b1);
            check("R7 ready held", {31'd0, din_ready}, 32'd1);
         end
         din_valid = 1'b1;
         din = base + 16'(i);
         sof = sof_mask[i];
         @(negedge clk);
         sof = 1'b0;
         check_ctl("R4 data word", base + 16'(i), 1'b1, 1'b0);
         check("R3 ready count", {31'd0, din_ready}, {31'd0, (i < n - 1)});
      end
      din_valid = 1'b0;
      din = 16'hDEAD;
      @(negedge clk);
      check_ctl("R5 extend after last", 16'h0, 1'b0, 1'b1);
   endtask

   initial begin : watchdog
      #(20 * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic prev_urun;
      repeat (3) @(negedge clk);
      check_ctl("R1 in reset", 16'h0, 1'b0, 1'b0);
      check("R1 ready in reset", {31'd0, din_ready}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check_ctl("R1 after reset", 16'h0, 1'b0, 1'b0);
      check("R1 ready after reset", {31'd0, din_ready}, 32'd0);

      // R3: valid while idle is ignored
      din_valid = 1'b1; din = 16'h5555;
      repeat (2) begin
         @(negedge clk);
         check_ctl("R3 valid ignored in idle", 16'h0, 1'b0, 1'b0);
         check("R3 ready low in idle", {31'd0, din_ready}, 32'd0);
      end
      din_valid = 1'b0;

      prev_urun = 1'b0;
      for (int k = 0; k < 5; k++) begin
         logic [23:0] v;
         int n;
         v = VEC[k];
         set_cfg(v[23], v[22:19], v[18:16], v[15:8]);
         n = v[23] ? 12 : 8;
         pulse_sof();
         expect_hdr(prev_urun ? "R8 header with underrun" : "R2 header", prev_urun);
         send_words(n, 16'(16'h1000 * (k + 1)), (v[3:0] == 4'hF) ? -1 : int'(v[3:0]), 0);
         @(negedge clk);
         check_ctl("R5 idle after extend", 16'h0, 1'b0, 1'b0);
         prev_urun = (v[3:0] != 4'hF);
      end

      // R9 pending start, two pulses in one frame; R3 select frozen mid-frame
      set_cfg(1'b0, 4'h9, 3'b011, 8'h42);
      pulse_sof();
      expect_hdr("R8 header flag cleared", 1'b0);
      cfg_wide = 1'b1;
      send_words(8, 16'h7000, -1, 32'h0000_0028);
      set_cfg(1'b1, 4'h5, 3'b100, 8'h99);
      @(negedge clk);
      expect_hdr("R9 pending header follows extend", 1'b0);
      send_words(12, 16'h8000, -1, 0);
      @(negedge clk);
      check_ctl("R9 one extra frame only", 16'h0, 1'b0, 1'b0);
      @(negedge clk);
      check_ctl("R9 still idle", 16'h0, 1'b0, 1'b0);

      // R1 reset mid-frame
      pulse_sof();
      din_valid = 1'b1; din = 16'h1234;
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_ctl("R1 reset mid-frame", 16'h0, 1'b0, 1'b0);
      check("R1 ready reset mid-frame", {31'd0, din_ready}, 32'd0);
      din_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check_ctl("R1 idle after reset", 16'h0, 1'b0, 1'b0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule